// File: doc/BRIEF.md
# External Bus Turnaround Wait Scheduler

This block sits between the port that carries internal access requests and the timing engine of a static external memory controller. For each request it works out how many idle bus cycles must pass before the access can start. It holds a stall towards the requester while those cycles run out. It then raises a one-cycle go pulse, and the timing engine starts the access on that pulse.

The idle cycles depend on the access history. A read leaves the bus driven by the memory device for a programmed number of cycles. That bus-release period is set for each chip select (0 to 15 cycles) and is counted from one of two edges reported by the timing engine: the rising edge of the read strobe or the rising edge of the chip select. A per-chip-select mode bit picks the edge.

A write that follows a read always costs one extra turnaround cycle, on top of any release cycles still due. A change of the low-speed clock mode costs one reload cycle, added to the next external access. Accesses aimed at internal memory never wait on the external bus.

Top module: `turnaround_sched`

## Requirements
- R1: After reset the scheduler has no access history and no pending reload. With no request, stall and go are both 0. The first external access after reset starts in the cycle it is presented, with zero stall cycles.
- R2: An external write whose previous external access was a read waits one turnaround cycle on top of any release cycles still due. With a release count of 0 it waits exactly 1 cycle. An external read after a write waits 0 cycles.
- R3: An external read aimed at a chip select other than the one that did the previous read waits for the release cycles that remain.
- R4: An external read to the same chip select as the previous read waits no release cycles.
- R5: An external write after a read, to the same chip select, waits for the remaining release cycles plus 1.
- R6: A request with the internal flag set gets go in the cycle it is presented. This holds while a release countdown runs and while an external transfer is still in progress.
- R7: When the chip select's mode bit is 1, the release count is loaded on the read-strobe rising-edge pulse. A chip-select rising-edge pulse then loads nothing.
- R8: When the mode bit is 0, the release count is loaded on the chip-select rising-edge pulse. A read-strobe pulse then loads nothing.
- R9: The release count and the mode bit are latched from the configuration when the read is issued. A configuration change after issue does not alter the count that is then loaded. Each chip select has a 4-bit count field at bits [4*i+3:4*i] of the float configuration input, and its mode bit is bit i of the mode input.
- R10: A toggle of the low-speed clock mode input adds one cycle to the wait of the next external access only. That cycle adds to the turnaround cycle and to any release cycles.
- R11: The release countdown decrements by one each cycle and keeps running through internal accesses. A later external access waits only for the cycles that remain.
- R12: After go for an external access, further external requests stall until the transfer-done pulse. Their wait is evaluated in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented; held until go |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target chip select |
| req_internal | input | 1 | Target is internal memory |
| cfg_float | input | NUM_CS*4 | Release cycle count per chip select, 4 bits each |
| cfg_rdctl | input | NUM_CS | Release edge select per chip select (1 = read strobe, 0 = chip select) |
| slow_mode | input | 1 | Low-speed clock mode level |
| rd_rise | input | 1 | Pulse: read strobe rising edge of current transfer |
| cs_rise | input | 1 | Pulse: chip-select rising edge of current transfer |
| xfer_done | input | 1 | Pulse: current external transfer complete |
| stall | output | 1 | Request presented but not yet allowed |
| go | output | 1 | One-cycle start pulse for the presented request |

## Verification
The bench targets the places where the stall length depends on history:
- A read-then-write sequence with a zero release count must produce exactly one idle cycle. A design that overlaps the turnaround cycle with the release count shows a stall one cycle short.
- Pulses on the edge that the mode bit does not select must load nothing. A design that listens to both edges stalls a later read to another device.
- A configuration change made after a read has issued, and internal accesses placed in the middle of a countdown, must not lengthen the later wait. A design that reads live configuration, or that freezes the count during internal traffic, reports the wrong number of cycles.
- A low-speed mode toggle must cost exactly one cycle, and only once. A design that never clears the pending reload keeps stalling every following access.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TWS_NUM_CS = 4;
    localparam int TWS_FLT_W  = 4;
    localparam int TWS_WAIT_W = TWS_FLT_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_BUSY = 2'd2
    } phase_e;

    typedef struct packed {
        logic                 valid;
        logic                 was_read;
        logic                 rd_ctl;
        logic [TWS_FLT_W-1:0] flt;
    } hist_t;

    function automatic logic [TWS_WAIT_W-1:0] tws_gap(
        input logic                 flt_due,
        input logic [TWS_FLT_W-1:0] rel,
        input logic                 rw_due,
        input logic                 reload_due
    );
        logic [TWS_WAIT_W-1:0] g;
        g = flt_due ? TWS_WAIT_W'(rel) : '0;
        g = g + TWS_WAIT_W'(rw_due) + TWS_WAIT_W'(reload_due);
        return g;
    endfunction

endpackage

// File: rtl/tws_history.sv
module tws_history
    import tws_pkg::*;
#(
    parameter int NUM_CS = TWS_NUM_CS,
    parameter int CS_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        capture,
    input  logic                        cap_write,
    input  logic [CS_W-1:0]             cap_cs,
    input  logic [NUM_CS*TWS_FLT_W-1:0] cfg_float,
    input  logic [NUM_CS-1:0]           cfg_rdctl,
    output hist_t                       hist,
    output logic [CS_W-1:0]             hist_cs
);

    logic [TWS_FLT_W-1:0] flt_tab [NUM_CS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_slice
            assign flt_tab[gi] = cfg_float[gi*TWS_FLT_W +: TWS_FLT_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            hist_cs <= '0;
        end else if (capture) begin
            hist.valid    <= 1'b1;
            hist.was_read <= ~cap_write;
            hist.rd_ctl   <= cfg_rdctl[cap_cs];
            hist.flt      <= flt_tab[cap_cs];
            hist_cs       <= cap_cs;
        end
    end

endmodule

// File: rtl/tws_release_ctr.sv
module tws_release_ctr
    import tws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [TWS_FLT_W-1:0] load_val,
    output logic [TWS_FLT_W-1:0] rel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rel <= '0;
        end else if (load) begin
            rel <= load_val;
        end else if (rel != '0) begin
            rel <= rel - TWS_FLT_W'(1);
        end
    end

endmodule

// File: rtl/tws_reload_track.sv
module tws_reload_track (
    input  logic clk,
    input  logic rst,
    input  logic slow_mode,
    input  logic consume,
    output logic pend
);

    logic slow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q <= slow_mode;
            pend   <= 1'b0;
        end else begin
            slow_q <= slow_mode;
            if (slow_mode != slow_q) begin
                pend <= 1'b1;
            end else if (consume) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tws_sequencer.sv
module tws_sequencer
    import tws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_internal,
    input  logic                 cs_differs,
    input  hist_t                hist,
    input  logic [TWS_FLT_W-1:0] rel,
    input  logic                 reload_pend,
    input  logic                 xfer_done,
    output logic                 go,
    output logic                 stall,
    output logic                 ext_go,
    output logic                 consume,
    output phase_e               phase
);

    phase_e                phase_q, phase_d;
    logic [TWS_WAIT_W-1:0] wcnt_q, wcnt_d;
    logic [TWS_WAIT_W-1:0] gap;
    logic                  ext_req, int_req, flt_due, rw_due;

    always_comb begin
        ext_req = req_valid && !req_internal;
        int_req = req_valid && req_internal;
        rw_due  = hist.valid && hist.was_read && req_write;
        flt_due = hist.valid && hist.was_read && (req_write || cs_differs);
        gap     = tws_gap(flt_due, rel, rw_due, reload_pend);

        go      = 1'b0;
        consume = 1'b0;
        phase_d = phase_q;
        wcnt_d  = wcnt_q;

        case (phase_q)
            PH_IDLE: begin
                if (int_req) begin
                    go = 1'b1;
                end else if (ext_req) begin
                    consume = 1'b1;
                    if (gap == '0) begin
                        go      = 1'b1;
                        phase_d = PH_BUSY;
                    end else begin
                        wcnt_d  = gap;
                        phase_d = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (!ext_req) begin
                    phase_d = PH_IDLE;
                end else if (wcnt_q <= TWS_WAIT_W'(1)) begin
                    go      = 1'b1;
                    phase_d = PH_BUSY;
                end else begin
                    wcnt_d = wcnt_q - TWS_WAIT_W'(1);
                end
            end
            PH_BUSY: begin
                if (int_req) begin
                    go = 1'b1;
                end
                if (xfer_done) begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase

        ext_go = go && !req_internal;
        stall  = req_valid && !go;
        phase  = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            wcnt_q  <= '0;
        end else begin
            phase_q <= phase_d;
            wcnt_q  <= wcnt_d;
        end
    end

endmodule

// File: rtl/turnaround_sched.sv
module turnaround_sched
    import tws_pkg::*;
#(
    parameter int NUM_CS = TWS_NUM_CS,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [CS_W-1:0]             req_cs,
    input  logic                        req_internal,
    input  logic [NUM_CS*TWS_FLT_W-1:0] cfg_float,
    input  logic [NUM_CS-1:0]           cfg_rdctl,
    input  logic                        slow_mode,
    input  logic                        rd_rise,
    input  logic                        cs_rise,
    input  logic                        xfer_done,
    output logic                        stall,
    output logic                        go
);

    hist_t                hist;
    logic [CS_W-1:0]      hist_cs;
    logic [TWS_FLT_W-1:0] rel;
    logic                 rel_load;
    logic                 reload_pend;
    logic                 ext_go;
    logic                 consume;
    logic                 cs_differs;
    logic                 hist_valid, hist_read;
    logic [1:0]           phase_bits;
    phase_e               phase;

    assign cs_differs = (req_cs != hist_cs);
    assign hist_valid = hist.valid;
    assign hist_read  = hist.was_read;
    assign phase_bits = phase;
    assign rel_load   = (phase == PH_BUSY) && hist.valid && hist.was_read &&
                        (hist.rd_ctl ? rd_rise : cs_rise);

    tws_history #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .capture   (ext_go),
        .cap_write (req_write),
        .cap_cs    (req_cs),
        .cfg_float (cfg_float),
        .cfg_rdctl (cfg_rdctl),
        .hist      (hist),
        .hist_cs   (hist_cs)
    );

    tws_release_ctr u_rel (
        .clk      (clk),
        .rst      (rst),
        .load     (rel_load),
        .load_val (hist.flt),
        .rel      (rel)
    );

    tws_reload_track u_reload (
        .clk       (clk),
        .rst       (rst),
        .slow_mode (slow_mode),
        .consume   (consume),
        .pend      (reload_pend)
    );

    tws_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_internal (req_internal),
        .cs_differs   (cs_differs),
        .hist         (hist),
        .rel          (rel),
        .reload_pend  (reload_pend),
        .xfer_done    (xfer_done),
        .go           (go),
        .stall        (stall),
        .ext_go       (ext_go),
        .consume      (consume),
        .phase        (phase)
    );

endmodule

// File: rtl/tws_checker.sv
module tws_checker
    import tws_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_internal,
    input logic                 go,
    input logic [1:0]           phase_bits,
    input logic                 hist_valid,
    input logic                 hist_read,
    input logic                 cs_differs,
    input logic [TWS_FLT_W-1:0] rel,
    input logic                 rel_load,
    input logic                 reload_pend
);

    // R1: first external request after reset starts at once
    a_r1_first_access_free: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && req_valid && !req_internal |-> go);

    // R6: internal requests never wait outside the wait phase
    a_r6_internal_immediate: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_internal && (phase_bits != PH_WAIT) |-> go);

    // R12: external request during a transfer is held
    a_r12_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_internal && (phase_bits == PH_BUSY) |-> !go);

    // R2: write after read never starts on its first evaluation cycle
    a_r2_turnaround_gap: assert property (@(posedge clk) disable iff (rst)
        (phase_bits == PH_IDLE) && req_valid && !req_internal && req_write &&
        hist_valid && hist_read |-> !go);

    // R4: same-device read after read with no reload due starts at once
    a_r4_same_read_free: assert property (@(posedge clk) disable iff (rst)
        (phase_bits == PH_IDLE) && req_valid && !req_internal && !req_write &&
        hist_valid && hist_read && !cs_differs && !reload_pend |-> go);

    // R11: countdown drops by one each cycle unless reloaded
    a_r11_countdown_step: assert property (@(posedge clk) disable iff (rst)
        !rel_load && (rel != '0) |=> rel == TWS_FLT_W'($past(rel) - TWS_FLT_W'(1)));

endmodule

bind turnaround_sched tws_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_internal (req_internal),
    .go           (go),
    .phase_bits   (phase_bits),
    .hist_valid   (hist_valid),
    .hist_read    (hist_read),
    .cs_differs   (cs_differs),
    .rel          (rel),
    .rel_load     (rel_load),
    .reload_pend  (reload_pend)
);

// File: tb/sim_turnaround_sched.sv
`timescale 1ns/1ps
module sim_turnaround_sched;

    localparam int NCS = 4;
    localparam int CSW = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid, req_write, req_internal;
    logic [CSW-1:0]   req_cs;
    logic [NCS*4-1:0] cfg_float;
    logic [NCS-1:0]   cfg_rdctl;
    logic             slow_mode, rd_rise, cs_rise, xfer_done;
    logic             stall, go;

    int    checks = 0;
    int    errors = 0;
    int    stall_run = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    turnaround_sched u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_internal(req_internal), .cfg_float(cfg_float),
        .cfg_rdctl(cfg_rdctl), .slow_mode(slow_mode), .rd_rise(rd_rise),
        .cs_rise(cs_rise), .xfer_done(xfer_done), .stall(stall), .go(go)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: count stall cycles per request, compare at go
    always @(negedge clk) begin : mon
        int    e;
        string t;
        if (!rst && req_valid) begin
            if (go) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected go", stall_run, -1);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(stall_run == e, t, stall_run, e);
                end
                stall_run = 0;
            end else if (stall) begin
                stall_run++;
            end
        end
    end

    task automatic issue(input bit wr, input int cs, input bit intl, input int exp, input string tag);
        @(posedge clk); #1;
        rd_rise = 1'b0; cs_rise = 1'b0; xfer_done = 1'b0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = wr; req_cs = CSW'(cs); req_internal = intl;
        do @(negedge clk); while (!go);
    endtask

    // kind: 0 no edge, 1 read strobe edge, 2 chip select edge
    task automatic close(input int kind);
        @(posedge clk); #1;
        req_valid = 1'b0;
        rd_rise   = (kind == 1);
        cs_rise   = (kind == 2);
        xfer_done = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            req_valid = 1'b0; rd_rise = 1'b0; cs_rise = 1'b0; xfer_done = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_cs = '0; req_internal = 1'b0;
        slow_mode = 1'b0; rd_rise = 1'b0; cs_rise = 1'b0; xfer_done = 1'b0;
        // cs0: 3 rd-edge, cs1: 5 cs-edge, cs2: 2 rd-edge, cs3: 0 cs-edge
        cfg_float = {4'd0, 4'd2, 4'd5, 4'd3};
        cfg_rdctl = 4'b0101;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(go == 1'b0, "R1 reset go", int'(go), 0);
        chk(stall == 1'b0, "R1 reset stall", int'(stall), 0);

        issue(1, 0, 0, 0, "R1 first access");               close(0);
        issue(0, 0, 0, 0, "R2 read after write");           close(1);
        issue(0, 1, 0, 3, "R3 read other device");          close(2);
        issue(0, 1, 0, 0, "R4 read same device");           close(2);
        issue(1, 1, 0, 6, "R5 write same device");          close(0);
        issue(0, 3, 0, 0, "R2 setup read");                 close(2);
        issue(1, 3, 0, 1, "R2 zero release turnaround");    close(0);
        // R7: mode 1, chip select edge must not load
        issue(0, 0, 0, 0, "R7 setup read");                 close(2);
        issue(0, 2, 0, 0, "R7 cs edge ignored");            close(1);
        issue(0, 0, 0, 2, "R7 rd edge loads");              close(1);
        // R8: mode 0, read strobe edge must not load
        issue(0, 1, 0, 3, "R3 read other device again");    close(1);
        issue(0, 2, 0, 0, "R8 rd edge ignored");            close(1);
        // R6 and R11: internal traffic during countdown
        issue(0, 0, 1, 0, "R6 internal during countdown");
        issue(1, 0, 1, 0, "R6 internal write");
        issue(0, 3, 0, 0, "R11 countdown exhausted");       close(2);
        issue(0, 1, 0, 0, "R8 setup read");                 close(2);
        issue(0, 0, 1, 0, "R6 internal a");
        issue(0, 0, 1, 0, "R6 internal b");
        issue(1, 1, 0, 4, "R11 remaining plus turnaround"); close(0);
        // R6 internal during transfer in progress
        issue(0, 0, 0, 0, "R6 setup read");
        issue(0, 2, 1, 0, "R6 internal while busy");        close(1);
        issue(0, 2, 0, 3, "R3 after busy internal");        close(1);
        // R9: configuration change after issue
        idle(8);
        issue(0, 1, 0, 0, "R9 setup read");                 close(2);
        cfg_float[7:4] = 4'd1;
        issue(0, 0, 0, 5, "R9 latched count");              close(1);
        cfg_float[7:4] = 4'd5;
        // R10: low-speed mode toggle
        idle(8);
        slow_mode = 1'b1;
        idle(2);
        issue(0, 0, 0, 1, "R10 reload cycle");              close(1);
        idle(4);
        issue(0, 1, 0, 0, "R10 reload once");               close(2);
        slow_mode = 1'b0;
        idle(8);
        issue(1, 1, 0, 2, "R10 reload plus turnaround");    close(0);
        // R12: external request during transfer waits for done
        issue(1, 2, 0, 0, "R12 setup write");
        fork
            issue(1, 3, 0, 3, "R12 held until done");
            begin
                repeat (3) @(posedge clk);
                #1 xfer_done = 1'b1;
                @(posedge clk);
                #1 xfer_done = 1'b0;
            end
        join
        close(0);
        idle(2);
        chk(exp_q.size() == 0, "R12 all requests granted", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule